// File: doc/BRIEF.md
# Dual-Parallel Quad-SPI Byte Striper

This block sits between a byte-oriented SPI flash engine and two quad-SPI flash devices wired side by side. The two devices share one chip select and one serial clock, and each has its own 4-bit data lane, so eight I/O lines are used in total. The engine hands over one byte slot at a time on a valid/ready stream. Each slot is tagged with three flags: whether it belongs to the data phase, whether it is a read, and whether it is the last slot of the transfer. The block turns each slot into nibbles on the lower lane, the upper lane, or both, and it controls the output enable of each lane. Clock generation and command sequencing are done outside the block. Each clock cycle in which `sck_en` is high is one serial clock period.

A two-bit target select chooses how bytes reach the devices. The same byte can go to both devices, or it can go to the lower device only or the upper device only. When striping is requested for a transfer, data-phase bytes are split in pairs. The even byte of each pair goes on the lower lane and the odd byte goes on the upper lane, and both lanes shift in the same cycles. On reads the two bytes are reassembled in their original order. Command and address bytes are never split. Unsplit reads in mirror mode return the bitwise OR of both devices. This lets a status poll report busy while either device is still working.

In striped mode, each device holds half of the logical space. The engine must therefore send the logical byte address halved in the address bytes. This block passes address bytes through unchanged.

Top module: `qss_striper`

## Requirements
- R1: After reset `cs_n` is 1, `sck_en`, both lane enables, `rx_valid` and `err_odd` are 0, and `in_ready` is 1.
- R2: Each accepted slot is shifted over BYTE_W/LANE_W consecutive cycles with `sck_en` high, most significant nibble first. `cs_n` goes low with the first slot of a transfer and stays low between slots. It returns to 1 in the cycle after the final nibble of the slot flagged last.
- R3: The select code `sel_i` decodes as 0 or 3 = both devices, 1 = lower device only, 2 = upper device only. For an unsplit write slot, every selected lane drives the byte with its enable at 1. An unselected lane keeps its enable at 0 and its outputs at 0.
- R4: With striping on, data-phase slots are taken in pairs. The first (even) byte drives the lower lane and the second (odd) byte drives the upper lane, in the same cycles, with both enables at 1, whatever the select code. After the first byte of a pair is accepted, nothing shifts, `cs_n` stays low and `in_ready` stays 1.
- R5: Slots with the data-phase flag at 0 are never split, even with striping on. They follow the select code.
- R6: `sel_i` and `stripe_i` are sampled only when the first slot of a transfer is accepted. Changing them later within the transfer has no effect.
- R7: During a read slot both lane enables stay 0. An unsplit read yields one byte with `rx_valid` high in the cycle after its final nibble. That byte is the lower lane's byte for code 1, the upper lane's byte for code 2, and the bitwise OR of the two for codes 0 and 3, so bit 0 (busy) reads 1 while either device is busy.
- R8: A striped read pair yields two bytes on consecutive cycles: the lower-lane byte first, then the upper-lane byte.
- R9: If a striped transfer ends on an even byte (odd count), that byte is shifted on the lower lane alone with the upper enable at 0. `err_odd` goes to 1 when that byte is accepted and stays 1 until the first slot of the next transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial clock period per shifting cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Target select code |
| stripe_i | input | 1 | Request striping of data-phase bytes |
| in_valid | input | 1 | Slot offered by the engine |
| in_ready | output | 1 | Slot can be accepted this cycle |
| in_byte | input | BYTE_W | Byte to write (ignored for read slots) |
| in_data | input | 1 | Slot belongs to the data phase |
| in_rx | input | 1 | Slot is a read |
| in_last | input | 1 | Last slot of the transfer |
| rx_valid | output | 1 | Received byte valid |
| rx_byte | output | BYTE_W | Received byte |
| cs_n | output | 1 | Shared chip select, active low |
| sck_en | output | 1 | Serial clock enable for this cycle |
| io_lo_o | output | LANE_W | Lower lane output nibble |
| io_lo_oe | output | 1 | Lower lane output enable |
| io_lo_i | input | LANE_W | Lower lane input nibble |
| io_hi_o | output | LANE_W | Upper lane output nibble |
| io_hi_oe | output | 1 | Upper lane output enable |
| io_hi_i | input | LANE_W | Upper lane input nibble |
| err_odd | output | 1 | Striped transfer ended on an odd count |

## Verification
The bench uses the default BYTE_W = 8 and LANE_W = 4, so every byte takes two nibbles. That small size lets it sweep all 256 byte values through every select code, for writes and for reads, including the OR merge of two differing device bytes. It also drives 128 striped write pairs and 256 striped read pairs through mixed select codes. It then covers the cases that depend on ordering: a mid-transfer change of select and stripe inputs, an unsplit command ahead of a split data phase, and the odd-count termination with its flag lifetime.

// File: rtl/qss_pkg.sv
package qss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PAIR  = 2'd2,
        ST_SHIFT = 2'd3
    } qss_state_e;

    typedef enum logic [1:0] {
        RXK_OR   = 2'd0,
        RXK_LO   = 2'd1,
        RXK_HI   = 2'd2,
        RXK_PAIR = 2'd3
    } qss_rxkind_e;

    localparam logic [1:0] SEL_LOWER = 2'd1;
    localparam logic [1:0] SEL_UPPER = 2'd2;

endpackage

// File: rtl/qss_lane.sv
module qss_lane #(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    input  logic              drive,
    input  logic [LANE_W-1:0] io_i,
    output logic [LANE_W-1:0] io_o,
    output logic              io_oe,
    output logic [BYTE_W-1:0] rx_word
);
    localparam int KEEP_W = BYTE_W - LANE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.tx = load_byte;
        end else if (shift) begin
            d.tx = q.tx << LANE_W;
        end
        if (shift) begin
            d.rx = {q.rx[KEEP_W-1:0], io_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign io_o    = drive ? q.tx[BYTE_W-1 -: LANE_W] : '0;
    assign io_oe   = drive;
    assign rx_word = {q.rx[KEEP_W-1:0], io_i};

endmodule

// File: rtl/qss_rxmerge.sv
module qss_rxmerge
    import qss_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  qss_rxkind_e       kind,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic [BYTE_W-1:0] hi_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              pend;
        logic [BYTE_W-1:0] pdata;
    } mrg_t;

    mrg_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (q.pend) begin
            d.valid = 1'b1;
            d.data  = q.pdata;
            d.pend  = 1'b0;
        end
        if (capture) begin
            d.valid = 1'b1;
            unique case (kind)
                RXK_LO:   d.data = lo_byte;
                RXK_HI:   d.data = hi_byte;
                RXK_PAIR: begin
                    d.data  = lo_byte;
                    d.pend  = 1'b1;
                    d.pdata = hi_byte;
                end
                default:  d.data = lo_byte | hi_byte;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_valid = q.valid;
    assign rx_byte  = q.data;

    AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |=> q.valid); // R8

endmodule

// File: rtl/qss_striper.sv
module qss_striper
    import qss_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_i,
    input  logic              stripe_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_data,
    input  logic              in_rx,
    input  logic              in_last,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              cs_n,
    output logic              sck_en,
    output logic [LANE_W-1:0] io_lo_o,
    output logic              io_lo_oe,
    input  logic [LANE_W-1:0] io_lo_i,
    output logic [LANE_W-1:0] io_hi_o,
    output logic              io_hi_oe,
    input  logic [LANE_W-1:0] io_hi_i,
    output logic              err_odd
);
    localparam int NIBS  = BYTE_W / LANE_W;
    localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam int LANES = 2;

    typedef struct packed {
        qss_state_e        st;
        logic [1:0]        sel;
        logic              stripe;
        logic [CNT_W-1:0]  cnt;
        logic              rx;
        logic              last;
        logic              en_lo;
        logic              en_hi;
        logic              striped;
        logic              err;
        logic [BYTE_W-1:0] held;
    } ctl_t;

    ctl_t q, d;

    logic              load;
    logic              shift;
    logic              capture;
    logic [BYTE_W-1:0] lo_load, hi_load;
    logic [1:0]        sel_use;
    logic              stripe_use;
    qss_rxkind_e       rx_kind;

    logic [LANES-1:0][LANE_W-1:0] lane_o, lane_i;
    logic [LANES-1:0][BYTE_W-1:0] lane_load, lane_rx;
    logic [LANES-1:0]             lane_oe, lane_drive;

    always_comb begin
        d          = q;
        load       = 1'b0;
        shift      = 1'b0;
        capture    = 1'b0;
        lo_load    = in_byte;
        hi_load    = in_byte;
        sel_use    = (q.st == ST_IDLE) ? sel_i : q.sel;
        stripe_use = (q.st == ST_IDLE) ? stripe_i : q.stripe;

        unique case (q.st)
            ST_IDLE, ST_WAIT: begin
                if (in_valid) begin
                    if (q.st == ST_IDLE) begin
                        d.sel    = sel_i;
                        d.stripe = stripe_i;
                        d.err    = 1'b0;
                    end
                    d.rx = in_rx;
                    if (stripe_use && in_data && !in_last) begin
                        d.held = in_byte;
                        d.st   = ST_PAIR;
                    end else begin
                        load   = 1'b1;
                        d.last = in_last;
                        d.cnt  = '0;
                        d.st   = ST_SHIFT;
                        if (stripe_use && in_data) begin
                            d.en_lo   = 1'b1;
                            d.en_hi   = 1'b0;
                            d.striped = 1'b1;
                            d.err     = 1'b1;
                        end else begin
                            d.en_lo   = (sel_use != SEL_UPPER);
                            d.en_hi   = (sel_use != SEL_LOWER);
                            d.striped = 1'b0;
                        end
                    end
                end
            end
            ST_PAIR: begin
                if (in_valid) begin
                    load      = 1'b1;
                    lo_load   = q.held;
                    hi_load   = in_byte;
                    d.en_lo   = 1'b1;
                    d.en_hi   = 1'b1;
                    d.striped = 1'b1;
                    d.last    = in_last;
                    d.cnt     = '0;
                    d.st      = ST_SHIFT;
                end
            end
            default: begin
                shift = 1'b1;
                if (q.cnt == CNT_W'(NIBS - 1)) begin
                    capture = q.rx;
                    d.st    = q.last ? ST_IDLE : ST_WAIT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.striped)              rx_kind = RXK_PAIR;
        else if (q.sel == SEL_LOWER) rx_kind = RXK_LO;
        else if (q.sel == SEL_UPPER) rx_kind = RXK_HI;
        else                        rx_kind = RXK_OR;
    end

    assign in_ready = (q.st != ST_SHIFT);
    assign cs_n     = (q.st == ST_IDLE);
    assign sck_en   = (q.st == ST_SHIFT);
    assign err_odd  = q.err;

    assign lane_i[0]     = io_lo_i;
    assign lane_i[1]     = io_hi_i;
    assign lane_load[0]  = lo_load;
    assign lane_load[1]  = hi_load;
    assign lane_drive[0] = sck_en && q.en_lo && !q.rx;
    assign lane_drive[1] = sck_en && q.en_hi && !q.rx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qss_lane #(
            .BYTE_W (BYTE_W),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .load_byte (lane_load[g]),
            .shift     (shift),
            .drive     (lane_drive[g]),
            .io_i      (lane_i[g]),
            .io_o      (lane_o[g]),
            .io_oe     (lane_oe[g]),
            .rx_word   (lane_rx[g])
        );
    end

    assign io_lo_o  = lane_o[0];
    assign io_lo_oe = lane_oe[0];
    assign io_hi_o  = lane_o[1];
    assign io_hi_oe = lane_oe[1];

    qss_rxmerge #(
        .BYTE_W (BYTE_W)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .kind     (rx_kind),
        .lo_byte  (lane_rx[0]),
        .hi_byte  (lane_rx[1]),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(sck_en)); // R2
    AST_RX_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_en && q.rx) |-> (!io_lo_oe && !io_hi_oe)); // R7
    AST_PAIR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == ST_PAIR) && sck_en && !q.rx) |-> (io_lo_oe && io_hi_oe)); // R4
    AST_ERR_STRIPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_odd) |-> q.stripe); // R9

endmodule

// File: tb/qss_striper_test.sv
module qss_striper_test;
    localparam int CLK_P = 10;
    localparam int BW    = 8;
    localparam int LW    = 4;
    localparam int NB    = BW / LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel_i = 2'd0;
    logic          stripe_i = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [BW-1:0] in_byte = '0;
    logic          in_data = 1'b0;
    logic          in_rx = 1'b0;
    logic          in_last = 1'b0;
    logic          rx_valid;
    logic [BW-1:0] rx_byte;
    logic          cs_n, sck_en;
    logic [LW-1:0] io_lo_o, io_hi_o;
    logic          io_lo_oe, io_hi_oe;
    logic [LW-1:0] io_lo_i = '0;
    logic [LW-1:0] io_hi_i = '0;
    logic          err_odd;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    qss_striper #(.BYTE_W(BW), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stripe_i(stripe_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .in_data(in_data), .in_rx(in_rx), .in_last(in_last),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .cs_n(cs_n), .sck_en(sck_en),
        .io_lo_o(io_lo_o), .io_lo_oe(io_lo_oe), .io_lo_i(io_lo_i),
        .io_hi_o(io_hi_o), .io_hi_oe(io_hi_oe), .io_hi_i(io_hi_i),
        .err_odd(err_odd)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] nib(input logic [BW-1:0] b, input int k);
        return LW'(b >> (BW - LW*(k+1)));
    endfunction

    task automatic push(input logic [BW-1:0] b, input logic dat, input logic rx, input logic last);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_data = dat; in_rx = rx; in_last = last;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic beat(input logic [BW-1:0] tlo, input logic [BW-1:0] thi,
                        input logic elo, input logic ehi, input logic rx,
                        input logic [BW-1:0] dlo, input logic [BW-1:0] dhi, input string tag);
        for (int k = 0; k < NB; k++) begin
            logic [LW-1:0] xl, xh;
            xl = (elo && !rx) ? nib(tlo, k) : '0;
            xh = (ehi && !rx) ? nib(thi, k) : '0;
            chk(sck_en && !cs_n, {tag, " R2 shifting"}, {sck_en, cs_n}, 2'b10);
            chk(io_lo_o == xl, {tag, " lower nibble"}, io_lo_o, xl);
            chk(io_hi_o == xh, {tag, " upper nibble"}, io_hi_o, xh);
            chk(io_lo_oe == (elo && !rx), {tag, " lower enable"}, io_lo_oe, elo && !rx);
            chk(io_hi_oe == (ehi && !rx), {tag, " upper enable"}, io_hi_oe, ehi && !rx);
            io_lo_i = nib(dlo, k);
            io_hi_i = nib(dhi, k);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic el, eh;
        logic [BW-1:0] a, b, x;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sck_en == 1'b0, "R1 cs/sck", {cs_n, sck_en}, 2'b10);
        chk(!io_lo_oe && !io_hi_oe, "R1 enables", {io_lo_oe, io_hi_oe}, 0);
        chk(in_ready && !rx_valid && !err_odd, "R1 ready/valid/err", {in_ready, rx_valid, err_odd}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 unsplit writes, every byte, every select code
        for (int m = 0; m < 4; m++) begin
            sel_i = 2'(m); stripe_i = 1'b0;
            el = (m != 2); eh = (m != 1);
            for (int v = 0; v < 256; v++) begin
                push(8'(v), 1'b1, 1'b0, 1'b1);
                beat(8'(v), 8'(v), el, eh, 1'b0, 0, 0, "R3");
                chk(cs_n == 1'b1, "R2 release after last", cs_n, 1);
            end
        end

        // R4/R5 striped writes preceded by an unsplit command
        for (int i = 0; i < 128; i++) begin
            sel_i = 2'(i % 4); stripe_i = 1'b1;
            el = ((i % 4) != 2); eh = ((i % 4) != 1);
            a = 8'(2*i); b = 8'(255 - 3*i); x = 8'(i ^ 8'h5A);
            push(x, 1'b0, 1'b0, 1'b0);
            beat(x, x, el, eh, 1'b0, 0, 0, "R5 command");
            chk(cs_n == 1'b0, "R2 held between slots", cs_n, 0);
            push(a, 1'b1, 1'b0, 1'b0);
            chk(!sck_en && !cs_n && in_ready, "R4 waiting for odd byte", {sck_en, cs_n, in_ready}, 3'b001);
            push(b, 1'b1, 1'b0, 1'b1);
            beat(a, b, 1'b1, 1'b1, 1'b0, 0, 0, "R4 pair");
            chk(cs_n == 1'b1, "R2 release after pair", cs_n, 1);
        end

        // R6 select and stripe sampled at transfer start only
        sel_i = 2'd1; stripe_i = 1'b0;
        push(8'hC3, 1'b0, 1'b0, 1'b0);
        beat(8'hC3, 8'hC3, 1'b1, 1'b0, 1'b0, 0, 0, "R6 first");
        sel_i = 2'd2; stripe_i = 1'b1;
        push(8'h96, 1'b1, 1'b0, 1'b1);
        chk(sck_en == 1'b1, "R6 no pairing after change", sck_en, 1);
        beat(8'h96, 8'h96, 1'b1, 1'b0, 1'b0, 0, 0, "R6 second");

        // R7 unsplit reads, mirror merges by OR
        for (int m = 0; m < 4; m++) begin
            sel_i = 2'(m); stripe_i = 1'b0;
            for (int v = 0; v < 256; v++) begin
                a = 8'(v); b = 8'(v*7 + 3);
                x = (m == 1) ? a : (m == 2) ? b : (a | b);
                push(8'hFF, 1'b1, 1'b1, 1'b1);
                beat(0, 0, 1'b1, 1'b1, 1'b1, a, b, "R7 read");
                chk(rx_valid && rx_byte == x, "R7 read byte", {rx_valid, rx_byte}, {1'b1, x});
                @(negedge clk);
                chk(!rx_valid, "R7 single byte", rx_valid, 0);
            end
        end

        // R8 striped reads come back lower first
        for (int v = 0; v < 256; v++) begin
            sel_i = 2'(v % 4); stripe_i = 1'b1;
            a = 8'(v); b = ~8'(v);
            push(8'h00, 1'b1, 1'b1, 1'b0);
            push(8'h00, 1'b1, 1'b1, 1'b1);
            beat(0, 0, 1'b1, 1'b1, 1'b1, a, b, "R8 read");
            chk(rx_valid && rx_byte == a, "R8 even byte", {rx_valid, rx_byte}, {1'b1, a});
            @(negedge clk);
            chk(rx_valid && rx_byte == b, "R8 odd byte", {rx_valid, rx_byte}, {1'b1, b});
            @(negedge clk);
            chk(!rx_valid, "R8 two bytes only", rx_valid, 0);
        end

        // R9 odd striped count
        sel_i = 2'd0; stripe_i = 1'b1;
        push(8'h3C, 1'b1, 1'b0, 1'b1);
        chk(err_odd == 1'b1, "R9 flag on accept", err_odd, 1);
        beat(8'h3C, 8'h00, 1'b1, 1'b0, 1'b0, 0, 0, "R9 lone byte");
        chk(err_odd == 1'b1, "R9 flag held", err_odd, 1);
        stripe_i = 1'b0;
        push(8'h11, 1'b1, 1'b0, 1'b1);
        chk(err_odd == 1'b0, "R9 cleared by next start", err_odd, 0);
        beat(8'h11, 8'h11, 1'b1, 1'b1, 1'b0, 0, 0, "R9 next");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule